// File: doc/BRIEF.md
# Accumulator/Quotient Shift Element

This unit is an arithmetic add-on that sits beside an 18-bit accumulator. It keeps its own 18-bit quotient register (MQ). It executes the instruction group whose four top bits read `1101` (octal 064 in the leading digits). For each accepted instruction it loads the caller's accumulator and link values and applies the operation. It then presents the new accumulator, MQ and link values on registered outputs and raises a single-cycle completion flag.

Two kinds of instruction are handled. Register transfers between AC and MQ finish in one clock. Shifts move one bit position per clock, and a counter loaded from the low six bits of the instruction word sets the number of steps. Long shifts treat AC (upper half) and MQ (lower half) as one 36-bit value. The AC-only shift leaves MQ alone. Setting bit 13 (octal 020000) of the word turns a shift into its sign-preserving form. While a shift runs, the unit reports busy and ignores further start strobes.

Top module: `eae_shift_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `ac_out`, `mq_out`, `link_out`, `done` and `busy` all read zero.
- R2: A word accepted with bits 17:14 not equal to `1101`, or a word in that group that matches none of the listed codes (for example octal 0641004 or 0640400), completes with zero latency. It returns `ac_out = ac_in` and `link_out = link_in` and leaves MQ unchanged.
- R3: The transfer codes act with zero latency as follows: octal 0652000 sets MQ to `ac_in`; 0641002 sets AC to the old MQ; 0650002 sets AC to `ac_in` OR MQ; 0650004 inverts MQ; 0650000 clears MQ. In each case the registers that the code does not name are set to `ac_in`, `link_in` and the old MQ.
- R4: Octal 0640500+n shifts {AC,MQ} right by n and fills the vacated bits with `link_in`. The form 0660500+n fills them with AC bit 17 instead.
- R5: Octal 0640600+n shifts {AC,MQ} left by n and feeds zeros in at MQ bit 0. The form 0660600+n holds AC bit 17 and shifts only the lower 35 bits.
- R6: Octal 0640700+n shifts only AC left by n and feeds in zeros, with MQ unchanged. The form 0660700+n holds AC bit 17.
- R7: The shift count n is bits 5:0 of the word (0 to 63), and the unit moves one position per clock. `done` appears n clock edges after the edge that accepts `start`. A count of zero completes at once with no shift.
- R8: `busy` is high from the accepting edge until the last step. A `start` seen while busy has no effect on the result or on MQ.
- R9: Shifts never change LINK: `link_out` equals `link_in` of the shift.
- R10: `done` is high for exactly one cycle per accepted instruction and is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe that accepts `instr` when not busy |
| instr | input | 18 | Instruction word |
| ac_in | input | 18 | Accumulator value supplied with the instruction |
| link_in | input | 1 | Link value supplied with the instruction |
| ac_out | output | 18 | Resulting accumulator |
| mq_out | output | 18 | Quotient register |
| link_out | output | 1 | Resulting link |
| done | output | 1 | One-cycle completion flag |
| busy | output | 1 | High while a shift is stepping |

## Verification
Every shift form, plain and signed, is run with counts 0 to 36 over four operand patterns. A lone AC sign bit with a set MQ bit 0 shows sign fill against link fill and shows bits crossing the AC/MQ seam. Alternating bit patterns with a set link show an off-by-one count or a missing step. An all-ones AC with an empty MQ, and a mixed pattern, show whether the sign bit is held on left shifts. Directed cases then cover each transfer code, unlisted and out-of-group words, a start strobe during a shift, the maximum count of 63, and the width of the done pulse.

// File: rtl/eae_pkg.sv
package eae_pkg;
  localparam int IW = 18;
  localparam int CW = 6;

  typedef enum logic [3:0] {
    OP_NONE, OP_LRS, OP_LLS, OP_ALS,
    OP_LACQ, OP_CLQ, OP_OMQ, OP_CMQ, OP_LMQ
  } eae_op_e;

  typedef struct packed {
    eae_op_e       op;
    logic          sgn;
    logic [CW-1:0] cnt;
  } eae_cmd_t;
endpackage

// File: rtl/eae_decode.sv
module eae_decode
  import eae_pkg::*;
(
  input  logic [IW-1:0] instr,
  output eae_cmd_t      cmd
);
  always_comb begin
    cmd.op  = OP_NONE;
    cmd.sgn = instr[13];
    cmd.cnt = instr[CW-1:0];
    if (instr[17:14] == 4'b1101) begin
      if (instr[12:9] == 4'b0000 && instr[8]) begin
        case (instr[7:6])
          2'b01:   cmd.op = OP_LRS;
          2'b10:   cmd.op = OP_LLS;
          2'b11:   cmd.op = OP_ALS;
          default: cmd.op = OP_NONE;
        endcase
      end else begin
        case (instr[13:0])
          14'o01002: cmd.op = OP_LACQ;
          14'o10000: cmd.op = OP_CLQ;
          14'o10002: cmd.op = OP_OMQ;
          14'o10004: cmd.op = OP_CMQ;
          14'o12000: cmd.op = OP_LMQ;
          default:   cmd.op = OP_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/eae_step.sv
module eae_step
  import eae_pkg::*;
#(
  parameter int DW = 18
) (
  input  eae_op_e       op,
  input  logic          sgn,
  input  logic [DW-1:0] ac,
  input  logic [DW-1:0] mq,
  input  logic          link,
  output logic [DW-1:0] nac,
  output logic [DW-1:0] nmq
);
  always_comb begin
    nac = ac;
    nmq = mq;
    case (op)
      OP_LRS: begin
        nac = {(sgn ? ac[DW-1] : link), ac[DW-1:1]};
        nmq = {ac[0], mq[DW-1:1]};
      end
      OP_LLS: begin
        nac = {ac[DW-2:0], mq[DW-1]};
        nmq = {mq[DW-2:0], 1'b0};
        if (sgn) nac[DW-1] = ac[DW-1];
      end
      OP_ALS: begin
        nac = {ac[DW-2:0], 1'b0};
        if (sgn) nac[DW-1] = ac[DW-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eae_count.sv
module eae_count
  import eae_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] n,
  output logic          busy,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= n;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign last = (cnt == CW'(1));

  AST_ONE_STEP_PER_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> (cnt == $past(cnt) - 1'b1)); // R7
endmodule

// File: rtl/eae_shift_unit.sv
module eae_shift_unit
  import eae_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] ac_in,
  input  logic          link_in,
  output logic [DW-1:0] ac_out,
  output logic [DW-1:0] mq_out,
  output logic          link_out,
  output logic          done,
  output logic          busy
);
  eae_cmd_t      cmd;
  eae_op_e       op_q;
  logic          sgn_q;
  logic [DW-1:0] ac_q, mq_q, nac, nmq;
  logic          link_q, done_q, busy_w, last_w;
  logic          accept, is_shift, load;

  eae_decode u_dec (.instr(instr), .cmd(cmd));

  assign accept   = start && !busy_w;
  assign is_shift = (cmd.op == OP_LRS) || (cmd.op == OP_LLS) || (cmd.op == OP_ALS);
  assign load     = accept && is_shift && (cmd.cnt != '0);

  eae_count u_cnt (
    .clk(clk), .rst(rst), .load(load), .n(cmd.cnt),
    .busy(busy_w), .last(last_w)
  );

  eae_step #(.DW(DW)) u_step (
    .op(op_q), .sgn(sgn_q), .ac(ac_q), .mq(mq_q), .link(link_q),
    .nac(nac), .nmq(nmq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_NONE;
      sgn_q  <= 1'b0;
      ac_q   <= '0;
      mq_q   <= '0;
      link_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q   <= cmd.op;
        sgn_q  <= cmd.sgn;
        ac_q   <= ac_in;
        link_q <= link_in;
        done_q <= !load;
        case (cmd.op)
          OP_LACQ: ac_q <= mq_q;
          OP_OMQ:  ac_q <= ac_in | mq_q;
          OP_CLQ:  mq_q <= '0;
          OP_CMQ:  mq_q <= ~mq_q;
          OP_LMQ:  mq_q <= ac_in;
          default: ;
        endcase
      end else if (busy_w) begin
        ac_q   <= nac;
        mq_q   <= nmq;
        done_q <= last_w;
      end
    end
  end

  assign ac_out   = ac_q;
  assign mq_out   = mq_q;
  assign link_out = link_q;
  assign done     = done_q;
  assign busy     = busy_w;

  AST_LAST_STEP_DONE: assert property (@(posedge clk) disable iff (rst)
    (busy_w && last_w) |=> done_q); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy_w && !last_w) |=> busy_w); // R8
  AST_LINK_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    busy_w |=> $stable(link_q)); // R9
  AST_ALS_KEEPS_MQ: assert property (@(posedge clk) disable iff (rst)
    (busy_w && op_q == OP_ALS) |=> $stable(mq_q)); // R6
  AST_SIGN_HELD_LEFT: assert property (@(posedge clk) disable iff (rst)
    (busy_w && sgn_q && op_q != OP_LRS) |=> $stable(ac_q[DW-1])); // R5
  AST_CLEAR_MQ: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd.op == OP_CLQ) |=> (mq_q == '0)); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_w); // R10
endmodule

// File: tb/eae_shift_unit_bench.sv
module eae_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [17:0] instr = '0;
  logic [17:0] ac_in = '0;
  logic        link_in = 1'b0;
  logic [17:0] ac_out, mq_out;
  logic        link_out, done, busy;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  eae_shift_unit u_eae_shift_unit (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .ac_in(ac_in),
    .link_in(link_in), .ac_out(ac_out), .mq_out(mq_out),
    .link_out(link_out), .done(done), .busy(busy)
  );

  localparam logic [17:0] OPS [6] = '{18'o640500, 18'o640600, 18'o640700,
                                      18'o660500, 18'o660600, 18'o660700};
  localparam logic [36:0] PATS [4] = '{
    {18'o400000, 18'o000001, 1'b0},
    {18'o252525, 18'o525252, 1'b1},
    {18'o777777, 18'o000000, 1'b0},
    {18'o123456, 18'o765432, 1'b1}
  };

  task automatic check(input bit ok, input string req, input string info);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s", req, info);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  task automatic do_op(input logic [17:0] w, input logic [17:0] a,
                       input logic l, output int lat);
    @(negedge clk);
    start = 1'b1; instr = w; ac_in = a; link_in = l;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 80) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic logic [35:0] ref_shift(input logic [17:0] w, input logic [17:0] a,
                                            input logic [17:0] m, input logic l, input int n);
    logic [35:0] v;
    logic [71:0] ext;
    logic [35:0] r;
    logic [17:0] ra;
    logic        sg, f;
    v  = {a, m};
    sg = w[13];
    f  = sg ? a[17] : l;
    r  = v;
    case (w[7:6])
      2'b01: begin ext = {{36{f}}, v} >> n; r = ext[35:0]; end
      2'b10: begin r = v << n; if (sg) r[35] = a[17]; end
      2'b11: begin ra = a << n; if (sg) ra[17] = a[17]; r = {ra, m}; end
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R7 watchdog expired");
    summary();
  end

  initial begin
    int lat;
    logic [35:0] expv;
    logic [17:0] w;
    string tag [6];
    tag = '{"R4", "R5", "R6", "R4", "R5", "R6"};

    // R1: reset state
    repeat (3) @(negedge clk);
    check(ac_out == 0 && mq_out == 0 && !link_out && !done && !busy, "R1",
          $sformatf("during reset ac=%o mq=%o l=%b d=%b b=%b exp all 0",
                    ac_out, mq_out, link_out, done, busy));
    rst = 1'b0;
    @(negedge clk);
    check(ac_out == 0 && mq_out == 0 && !done && !busy, "R1",
          $sformatf("after reset ac=%o mq=%o exp 0", ac_out, mq_out));

    // Table walk: every shift form, four patterns, counts 0..36 (R4 R5 R6 R7 R9)
    for (int o = 0; o < 6; o++) begin
      for (int p = 0; p < 4; p++) begin
        for (int n = 0; n <= 36; n++) begin
          do_op(18'o652000, PATS[p][18:1], 1'b0, lat);
          w = OPS[o] | 18'(n);
          expv = ref_shift(w, PATS[p][36:19], PATS[p][18:1], PATS[p][0], n);
          do_op(w, PATS[p][36:19], PATS[p][0], lat);
          check(ac_out == expv[35:18] && mq_out == expv[17:0] &&
                link_out == PATS[p][0] && lat == n,
                $sformatf("%s/R7/R9", tag[o]),
                $sformatf("w=%o ac=%o mq=%o l=%b lat=%0d exp ac=%o mq=%o l=%b lat=%0d",
                          w, ac_out, mq_out, link_out, lat,
                          expv[35:18], expv[17:0], PATS[p][0], n));
        end
      end
    end

    // R3: transfers
    do_op(18'o652000, 18'o123456, 1'b1, lat);
    check(mq_out == 18'o123456 && ac_out == 18'o123456 && link_out && lat == 0, "R3",
          $sformatf("load MQ mq=%o ac=%o lat=%0d exp 123456 123456 0", mq_out, ac_out, lat));
    do_op(18'o641002, 18'o707070, 1'b0, lat);
    check(ac_out == 18'o123456 && mq_out == 18'o123456 && lat == 0, "R3",
          $sformatf("MQ to AC ac=%o mq=%o exp 123456 123456", ac_out, mq_out));
    do_op(18'o650002, 18'o000001, 1'b0, lat);
    check(ac_out == 18'o123457 && mq_out == 18'o123456, "R3",
          $sformatf("OR MQ ac=%o exp 123457", ac_out));
    do_op(18'o650004, 18'o000000, 1'b0, lat);
    check(mq_out == 18'o654321 && ac_out == 18'o000000, "R3",
          $sformatf("invert MQ mq=%o ac=%o exp 654321 0", mq_out, ac_out));
    do_op(18'o650000, 18'o000077, 1'b0, lat);
    check(mq_out == 18'o000000 && ac_out == 18'o000077, "R3",
          $sformatf("clear MQ mq=%o ac=%o exp 0 77", mq_out, ac_out));

    // R10: done lasts one cycle
    @(negedge clk);
    check(!done, "R10", $sformatf("done=%b one cycle after completion exp 0", done));

    // R2: words outside the group or unlisted in it
    do_op(18'o652000, 18'o555555, 1'b0, lat);
    do_op(18'o200123, 18'o111111, 1'b1, lat);
    check(ac_out == 18'o111111 && link_out && mq_out == 18'o555555 && lat == 0, "R2",
          $sformatf("outside group ac=%o l=%b mq=%o lat=%0d exp 111111 1 555555 0",
                    ac_out, link_out, mq_out, lat));
    do_op(18'o641004, 18'o222222, 1'b0, lat);
    check(ac_out == 18'o222222 && !link_out && mq_out == 18'o555555 && lat == 0, "R2",
          $sformatf("unlisted 641004 ac=%o mq=%o exp 222222 555555", ac_out, mq_out));
    do_op(18'o640400, 18'o333333, 1'b1, lat);
    check(ac_out == 18'o333333 && mq_out == 18'o555555 && lat == 0, "R2",
          $sformatf("unlisted 640400 ac=%o mq=%o exp 333333 555555", ac_out, mq_out));

    // R8: start while busy is ignored
    do_op(18'o652000, 18'o000777, 1'b0, lat);
    @(negedge clk);
    start = 1'b1; instr = 18'o640512; ac_in = 18'o400000; link_in = 1'b0;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    check(busy && !done, "R8", $sformatf("busy=%b done=%b after accept exp 1 0", busy, done));
    @(negedge clk);
    lat = 1;
    start = 1'b1; instr = 18'o652000; ac_in = 18'o000000;
    @(negedge clk);
    lat = 2;
    start = 1'b0;
    while (!done && lat < 80) begin
      @(negedge clk);
      lat++;
    end
    expv = ref_shift(18'o640512, 18'o400000, 18'o000777, 1'b0, 10);
    check(ac_out == expv[35:18] && mq_out == expv[17:0] && lat == 10, "R8",
          $sformatf("ac=%o mq=%o lat=%0d exp %o %o 10", ac_out, mq_out, lat,
                    expv[35:18], expv[17:0]));
    check(!busy, "R10", $sformatf("busy=%b with done exp 0", busy));

    // R7: largest count
    do_op(18'o652000, 18'o777777, 1'b0, lat);
    do_op(18'o640577, 18'o777777, 1'b0, lat);
    check(ac_out == 0 && mq_out == 0 && lat == 63, "R7",
          $sformatf("count 63 ac=%o mq=%o lat=%0d exp 0 0 63", ac_out, mq_out, lat));

    summary();
  end
endmodule